// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This block is the combinational arithmetic and logic datapath of a small 8-bit processor, together with the register that holds its condition flags. It takes two operands, a carry-in and a 3-bit operation code. It produces the result at once. It updates five status flags on a clock edge when the caller asks for it.

Besides the usual sign, zero and carry flags, it produces two more. One is a half-carry out of the low nibble, which decimal-adjust sequences rely on. The other is an even-parity flag. The flag register can also be reloaded in one cycle from a saved word, which is how an interrupt or call return restores the state it saved.

Compare behaves as a subtract that leaves no result behind. The result-write strobe tells the surrounding datapath whether the result is to be stored.

Top module: `alu_flag_unit`

## Requirements
- R1: The flag word is 8 bits: sign at bit 7, zero at bit 6, auxiliary carry at bit 4, parity at bit 2 and carry at bit 0. Bits 5, 3 and 1 always read 0.
- R2: `result` follows the operation code combinationally:
  - 0 = a+b
  - 1 = a+b+cin
  - 2 = a-b
  - 3 = a-b-cin
  - 4 = a-b (compare)
  - 5 = a AND b
  - 6 = a OR b
  - 7 = a XOR b
  
  The value is taken modulo 256. `cin` is used only by codes 1 and 3.
- R3: On a flag update, sign takes bit 7 of the result.
- R4: On a flag update, zero is 1 exactly when all eight result bits are 0.
- R5: On a flag update, auxiliary carry is set as follows:
  - For codes 0 and 1 it is the carry out of bit 3, that is, the low nibbles plus the carry-in exceed 15.
  - For codes 2, 3 and 4 it is the borrow into bit 4, that is, a[3:0] is less than b[3:0] plus the borrow-in.
  - For codes 5 to 7 it is 0.
- R6: On a flag update, parity is 1 exactly when the result has an even number of 1 bits.
- R7: On a flag update, carry is set as follows:
  - For codes 0 and 1 it is the carry out of bit 7.
  - For codes 2, 3 and 4 it is the borrow (a is less than b plus the borrow-in).
  - For codes 5 to 7 it is cleared.
- R8: Compare (code 4) sets every flag exactly as subtract (code 2) does, and it holds `res_we` low. `res_we` is high for every other code.
- R9: The flags change only on a rising clock edge with `flag_we` high. Otherwise they hold, whatever the operands or code.
- R10: With `flag_ld` high, a rising edge loads the flags from `flag_din`, with bits 5, 3 and 1 forced to 0. This load takes priority over `flag_we`.
- R11: An active-low `rst_n` clears the flag word to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| cin | input | 1 | Carry/borrow-in for codes 1 and 3 |
| op | input | 3 | Operation code |
| flag_we | input | 1 | Update flags from this operation |
| flag_ld | input | 1 | Load flags from flag_din |
| flag_din | input | 8 | Saved flag word to restore |
| result | output | 8 | Operation result |
| res_we | output | 1 | Result is to be written (low for compare) |
| flags | output | 8 | Flag register |

## Verification
The bench builds the block with its default parameters: an 8-bit data path (`W` = 8) with the half-carry taken at bit 4 (`NIB` = 4). These defaults put the interesting boundaries within a handful of directed operands:
- wrap-around at 0xFF + 1;
- a borrow out of 0x00;
- a half-carry at 0x0F + 1;
- a half-borrow at 0x10 − 1.

A reference model in the bench computes each result and flag in integer arithmetic. The bench then checks the hold, reload and load-priority cases on the register.

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic [2:0]   op,
  input  logic         flag_we,
  input  logic         flag_ld,
  input  logic [W-1:0] flag_din,
  output logic [W-1:0] result,
  output logic         res_we,
  output logic [W-1:0] flags
);
  localparam int SIGN_B = W - 1;
  localparam int ZERO_B = W - 2;
  localparam int AUX_B  = NIB;
  localparam int PAR_B  = NIB / 2;
  localparam int CY_B   = 0;
  localparam logic [W-1:0] USED = (W'(1) << SIGN_B) | (W'(1) << ZERO_B) |
                                  (W'(1) << AUX_B) | (W'(1) << PAR_B) | (W'(1) << CY_B);

  localparam logic [2:0] OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBB = 3'd3,
                         OP_CMP = 3'd4, OP_AND = 3'd5, OP_OR  = 3'd6, OP_XOR = 3'd7;

  logic [W:0]   wide;
  logic [NIB:0] lo;
  logic         use_c, arith;
  logic [W-1:0] nf;

  assign use_c  = ((op == OP_ADC) || (op == OP_SBB)) && cin;
  assign arith  = (op <= OP_CMP);
  assign res_we = (op != OP_CMP);

  always_comb begin
    wide = '0;
    lo   = '0;
    case (op)
      OP_ADD, OP_ADC: begin
        wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, use_c};
        lo   = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, use_c};
      end
      OP_SUB, OP_SBB, OP_CMP: begin
        wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, use_c};
        lo   = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, use_c};
      end
      OP_AND:  wide = {1'b0, a & b};
      OP_OR:   wide = {1'b0, a | b};
      default: wide = {1'b0, a ^ b};
    endcase
  end

  assign result = wide[W-1:0];

  always_comb begin
    nf         = '0;
    nf[SIGN_B] = result[W-1];
    nf[ZERO_B] = (result == '0);
    nf[AUX_B]  = arith && lo[NIB];
    nf[PAR_B]  = ~^result;
    nf[CY_B]   = arith && wide[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags <= '0;
    else if (flag_ld) flags <= flag_din & USED;
    else if (flag_we) flags <= nf;
  end
endmodule

module alu_flag_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] a,
  input logic [2:0] op,
  input logic       flag_we,
  input logic       flag_ld,
  input logic [7:0] flag_din,
  input logic [7:0] result,
  input logic       res_we,
  input logic [7:0] flags
);
  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & 8'h2A) == 8'h00);
  a_r8_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd4) |-> !res_we);
  a_r8_other_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op != 3'd4) |-> res_we);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_we && !flag_ld) |=> $stable(flags));
  a_r3_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !flag_ld) |=> flags[7] == $past(result[7]));
  a_r4_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !flag_ld) |=> flags[6] == ($past(result) == 8'h00));
  a_r6_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !flag_ld) |=> flags[2] == ~^$past(result));
  a_r7_logic_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !flag_ld && op >= 3'd5) |=> !flags[0] && !flags[4]);
  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ld |=> flags == ($past(flag_din) & 8'hD5));
endmodule

bind alu_flag_unit alu_flag_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .a(a), .op(op), .flag_we(flag_we), .flag_ld(flag_ld),
  .flag_din(flag_din), .result(result), .res_we(res_we), .flags(flags)
);

// File: tb/alu_flag_unit_test.sv
module alu_flag_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a = '0, b = '0, flag_din = '0;
  logic       cin = 1'b0, flag_we = 1'b0, flag_ld = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] result, flags;
  logic       res_we;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  alu_flag_unit uut (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin), .op(op),
    .flag_we(flag_we), .flag_ld(flag_ld), .flag_din(flag_din),
    .result(result), .res_we(res_we), .flags(flags)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [2:0] o, input logic [7:0] x, y, input logic ci);
    int xi, yi, c, r, l;
    logic cy, ac;
    logic [7:0] res, fl;
    xi = int'(x); yi = int'(y);
    c  = (o == 3'd1 || o == 3'd3) ? int'(ci) : 0;
    cy = 1'b0; ac = 1'b0;
    if (o <= 3'd1) begin
      r = xi + yi + c; l = (xi % 16) + (yi % 16) + c;
      cy = r > 255; ac = l > 15;
    end else if (o <= 3'd4) begin
      r = xi - yi - c; l = (xi % 16) - (yi % 16) - c;
      cy = r < 0; ac = l < 0;
    end else if (o == 3'd5) r = int'(x & y);
    else if (o == 3'd6)     r = int'(x | y);
    else                    r = int'(x ^ y);
    res = 8'(r & 255);
    fl  = {res[7], res == 8'h00, 1'b0, ac, 1'b0, ~^res, 1'b0, cy};
    return {res, fl};
  endfunction

  task automatic do_op(input logic [2:0] o, input logic [7:0] x, y, input logic ci);
    logic [15:0] e;
    @(negedge clk);
    op = o; a = x; b = y; cin = ci; flag_we = 1'b1; flag_ld = 1'b0;
    e = model(o, x, y, ci);
    #1;
    chk("R2 result", int'(result), int'(e[15:8]));
    chk("R8 res_we", int'(res_we), (o == 3'd4) ? 0 : 1);
    @(negedge clk);
    flag_we = 1'b0;
    chk("R3 sign",   int'(flags[7]), int'(e[7]));
    chk("R4 zero",   int'(flags[6]), int'(e[6]));
    chk("R5 aux",    int'(flags[4]), int'(e[4]));
    chk("R6 parity", int'(flags[2]), int'(e[2]));
    chk("R7 carry",  int'(flags[0]), int'(e[0]));
    chk("R1 unused", int'(flags & 8'h2A), 0);
  endtask

  task automatic t_reset();
    #1;
    chk("R11 reset", int'(flags), 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_add();
    do_op(3'd0, 8'h0F, 8'h01, 1'b0);
    do_op(3'd0, 8'hFF, 8'h01, 1'b0);
    do_op(3'd0, 8'h7F, 8'h01, 1'b1);
    do_op(3'd1, 8'hFE, 8'h01, 1'b1);
    do_op(3'd1, 8'h08, 8'h07, 1'b1);
  endtask

  task automatic t_sub();
    do_op(3'd2, 8'h10, 8'h01, 1'b0);
    do_op(3'd2, 8'h00, 8'h01, 1'b0);
    do_op(3'd3, 8'h05, 8'h05, 1'b1);
    do_op(3'd3, 8'h50, 8'h20, 1'b0);
  endtask

  task automatic t_cmp();
    logic [7:0] fsub;
    do_op(3'd2, 8'h31, 8'h42, 1'b0);
    fsub = flags;
    do_op(3'd0, 8'h00, 8'h00, 1'b0);
    do_op(3'd4, 8'h31, 8'h42, 1'b0);
    chk("R8 cmp equals sub", int'(flags), int'(fsub));
    do_op(3'd4, 8'h20, 8'h20, 1'b1);
  endtask

  task automatic t_logic();
    do_op(3'd0, 8'hFF, 8'hFF, 1'b0);
    do_op(3'd5, 8'hF0, 8'h0F, 1'b1);
    do_op(3'd0, 8'hFF, 8'hFF, 1'b0);
    do_op(3'd6, 8'h81, 8'h02, 1'b0);
    do_op(3'd7, 8'hAA, 8'h55, 1'b0);
  endtask

  task automatic t_hold();
    logic [7:0] keep;
    do_op(3'd0, 8'hFF, 8'h01, 1'b0);
    keep = flags;
    @(negedge clk);
    op = 3'd2; a = 8'h00; b = 8'h7E; flag_we = 1'b0; flag_din = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    chk("R9 hold", int'(flags), int'(keep));
  endtask

  task automatic t_load();
    @(negedge clk);
    flag_din = 8'hFF; flag_ld = 1'b1;
    @(negedge clk);
    flag_ld = 1'b0;
    chk("R10 load mask", int'(flags), 8'hD5);
    op = 3'd0; a = 8'h01; b = 8'h01; flag_we = 1'b1; flag_ld = 1'b1; flag_din = 8'h41;
    @(negedge clk);
    flag_we = 1'b0; flag_ld = 1'b0;
    chk("R10 load priority", int'(flags), 8'h41);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_hold();
    t_load();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule